// File: doc/BRIEF.md
# Quarter-Duty Third-Bias LCD Sequencer

This block turns a latched segment pattern into the time-multiplexed drive for a passive segment LCD with four common lines and a parameterised number of segment lines. It does not drive analog voltages. For every common pin and every segment pin it emits a 2-bit code, and an analog stage outside the block turns each code into one of four rails. The four rails are the top supply, one-third of the span, two-thirds of the span and the LCD bottom rail.

A divider counts oscillator-rate enable pulses and advances a four-slot scan. In each slot one common line is selected, and the segment codes follow the pattern row that belongs to that common. The whole level set is mirrored every frame of four slots, so the average voltage across every pixel is zero. A display-enable input blanks the glass by driving all pins to one level. The scan keeps running while blanked, and the pattern input is left alone.

Top module: `lcdq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every code on `com_lvl` and `seg_lvl` becomes 0 after that edge, and the scan restarts at slot 0 in the normal (non-mirrored) frame.
- R2: The slot index (0..3) advances by one, wrapping 3 to 0, after every `SLOT_DIV` clock edges at which `osc_en` is high. Edges with `osc_en` low do not count.
- R3: In a normal frame with the display on, the common pin equal to the slot index gets code 0 (top rail) and the other three get code 2 (two-thirds). Common c occupies `com_lvl[2c+1:2c]`.
- R4: In a normal frame with the display on, segment s gets code 3 (bottom rail) when `pattern[slot*N_SEG+s]` is 1 and code 1 (one-third) when it is 0. Segment s occupies `seg_lvl[2s+1:2s]`.
- R5: In a mirrored frame every code of R3 and R4 is replaced by 3 minus that code.
- R6: Frames alternate between normal and mirrored. The polarity flips each time the slot index wraps from 3 to 0.
- R7: While `disp_on` is low, every common and segment code is 0. The scan timing keeps advancing, and once `disp_on` returns high the outputs follow the current slot, frame and pattern.
- R8: Outputs are registered. A change on `pattern` or `disp_on` shows on the outputs after the next clock edge, and not before.
- R9: While the display is on, exactly one common pin carries an active code (0 or 3) at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable at oscillator rate |
| disp_on | input | 1 | High: display runs; low: all pins blanked |
| pattern | input | 4*N_SEG | Latched pixel bits, row c at [c*N_SEG +: N_SEG] |
| com_lvl | output | 8 | 2-bit level code per common pin |
| seg_lvl | output | 2*N_SEG | 2-bit level code per segment pin |

## Verification
The assertions check four things on every cycle: that exactly one common is active while the display is on, that all pins are flat when it is off, that the slot steps only on a divider tick, and that polarity flips only at the slot wrap. Only the bench's scenarios can show the exact pixel-to-pin mapping, the mirrored code values and the count of enables per slot. The bench compares every pin against an arithmetic model across several patterns, with dense and sparse enables, through blanking and through reset in mid-frame.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  localparam int COMS = 4;

  typedef enum logic [1:0] {
    LV_TOP      = 2'd0,
    LV_THIRD    = 2'd1,
    LV_TWOTHIRD = 2'd2,
    LV_BOTTOM   = 2'd3
  } lvl_e;

  // mirror a code about the mid-span when the frame is inverted
  function automatic logic [1:0] apply_pol(input lvl_e v, input logic inv);
    return inv ? ~v : v;
  endfunction
endpackage

// File: rtl/lcdq_divider.sv
module lcdq_divider #(
  parameter int SLOT_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  output logic tick
);
  localparam int CW = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = osc_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (osc_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcdq_phase.sv
module lcdq_phase (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic [1:0] slot,
  output logic       inv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= 2'd0;
      inv  <= 1'b0;
    end else if (tick) begin
      slot <= slot + 2'd1;
      if (slot == 2'd3) inv <= ~inv;
    end
  end
endmodule

// File: rtl/lcdq_levels.sv
module lcdq_levels
  import lcdq_pkg::*;
#(
  parameter int N_SEG = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              slot,
  input  logic                    inv,
  input  logic                    disp_on,
  input  logic [COMS*N_SEG-1:0]   pattern,
  output logic [2*COMS-1:0]       com_lvl,
  output logic [2*N_SEG-1:0]      seg_lvl
);
  logic [N_SEG-1:0]   row;
  logic [2*COMS-1:0]  com_d;
  logic [2*N_SEG-1:0] seg_d;

  assign row = pattern[slot*N_SEG +: N_SEG];

  for (genvar c = 0; c < COMS; c++) begin : g_com
    lvl_e base;
    assign base = (slot == 2'(c)) ? LV_TOP : LV_TWOTHIRD;
    assign com_d[2*c +: 2] = disp_on ? apply_pol(base, inv) : LV_TOP;
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    lvl_e base;
    assign base = row[s] ? LV_BOTTOM : LV_THIRD;
    assign seg_d[2*s +: 2] = disp_on ? apply_pol(base, inv) : LV_TOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_d;
      seg_lvl <= seg_d;
    end
  end
endmodule

// File: rtl/lcdq_sequencer.sv
module lcdq_sequencer
  import lcdq_pkg::*;
#(
  parameter int N_SEG    = 50,
  parameter int SLOT_DIV = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  osc_en,
  input  logic                  disp_on,
  input  logic [4*N_SEG-1:0]    pattern,
  output logic [7:0]            com_lvl,
  output logic [2*N_SEG-1:0]    seg_lvl
);
  logic       tick;
  logic [1:0] slot_q;
  logic       inv_q;

  lcdq_divider #(.SLOT_DIV(SLOT_DIV)) u_div (
    .clk(clk), .rst(rst), .osc_en(osc_en), .tick(tick)
  );

  lcdq_phase u_phase (
    .clk(clk), .rst(rst), .tick(tick), .slot(slot_q), .inv(inv_q)
  );

  lcdq_levels #(.N_SEG(N_SEG)) u_lvl (
    .clk(clk), .rst(rst), .slot(slot_q), .inv(inv_q), .disp_on(disp_on),
    .pattern(pattern), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcdq_sequencer_chk.sv
module lcdq_sequencer_chk #(
  parameter int N_SEG = 50
) (
  input logic               clk,
  input logic               rst,
  input logic               disp_on,
  input logic               tick,
  input logic [1:0]         slot_q,
  input logic               inv_q,
  input logic [7:0]         com_lvl,
  input logic [2*N_SEG-1:0] seg_lvl
);
  logic [3:0] act;
  always_comb begin
    for (int c = 0; c < 4; c++)
      act[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
  end

  a_r1_reset_flat: assert property (@(posedge clk)
    rst |=> (com_lvl == '0 && seg_lvl == '0));

  a_r9_one_active: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && disp_on) |-> $onehot(act));

  a_r7_blank_flat: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !disp_on) |-> (com_lvl == '0 && seg_lvl == '0));

  a_r2_hold_slot: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(slot_q));

  a_r2_step_slot: assert property (@(posedge clk) disable iff (rst)
    tick |=> (slot_q == $past(slot_q) + 2'd1));

  a_r6_flip_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && slot_q == 2'd3) |=> (inv_q != $past(inv_q)));

  a_r6_hold_pol: assert property (@(posedge clk) disable iff (rst)
    !(tick && slot_q == 2'd3) |=> $stable(inv_q));
endmodule

bind lcdq_sequencer lcdq_sequencer_chk #(.N_SEG(N_SEG)) u_chk (
  .clk(clk), .rst(rst), .disp_on(disp_on), .tick(tick), .slot_q(slot_q),
  .inv_q(inv_q), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcdq_sequencer_tb.sv
module lcdq_sequencer_tb_top;
  localparam int NS  = 5;
  localparam int DIV = 3;
  localparam int PW  = 4 * NS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            osc_en = 1'b0;
  logic            disp_on = 1'b0;
  logic [PW-1:0]   pattern = '0;
  logic [7:0]      com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int    n_run = 0;
  int    n_bad = 0;
  int    en_cnt = 0;
  string tag = "R1";
  logic [7:0]      exp_com = '0;
  logic [2*NS-1:0] exp_seg = '0;

  always #10 clk = ~clk;

  lcdq_sequencer #(.N_SEG(NS), .SLOT_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .osc_en(osc_en), .disp_on(disp_on),
    .pattern(pattern), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // arithmetic reference: slot and polarity from the number of enables seen
  always @(posedge clk) begin
    if (rst) begin
      en_cnt  <= 0;
      exp_com <= '0;
      exp_seg <= '0;
    end else begin
      int sl, pl;
      sl = (en_cnt / DIV) % 4;
      pl = (en_cnt / (4 * DIV)) % 2;
      for (int c = 0; c < 4; c++) begin
        int v;
        v = (c == sl) ? 0 : 2;
        if (pl == 1) v = 3 - v;
        exp_com[2*c +: 2] <= disp_on ? 2'(v) : 2'd0;
      end
      for (int s = 0; s < NS; s++) begin
        int v;
        v = pattern[sl*NS + s] ? 3 : 1;
        if (pl == 1) v = 3 - v;
        exp_seg[2*s +: 2] <= disp_on ? 2'(v) : 2'd0;
      end
      en_cnt <= en_cnt + (osc_en ? 1 : 0);
    end
  end

  task automatic check_now();
    n_run++;
    if (com_lvl !== exp_com || seg_lvl !== exp_seg) begin
      n_bad++;
      $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h (enables=%0d)",
               tag, com_lvl, seg_lvl, exp_com, exp_seg, en_cnt);
    end
  endtask

  // drive at negedge, compare at the following negedge
  task automatic run(input int cycles, input int en_every);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now();
      osc_en = ((i % en_every) == 0);
    end
  endtask

  logic finished = 1'b0;
  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      n_run++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check_now();
    @(negedge clk);
    rst = 0;
    disp_on = 1;
    pattern = 20'h0_0000;
    tag = "R2 R3 R4 R9";
    run(4 * DIV * 2 + 5, 1);
    pattern = 20'hF_FFFF;
    tag = "R3 R4 R5 R6";
    run(4 * DIV * 4, 1);
    pattern = 20'hA_5A5A;
    tag = "R2 sparse enables";
    run(4 * DIV * 3 * 3, 3);
    // walking single pixel through every position
    tag = "R4 R5 R8 walk";
    for (int b = 0; b < PW; b++) begin
      pattern = PW'(1) << b;
      run(DIV * 2 + 1, 1);
    end
    tag = "R7 blank";
    pattern = 20'h3_C96E;
    disp_on = 0;
    run(4 * DIV * 2 + 3, 1);
    tag = "R7 restore";
    disp_on = 1;
    run(4 * DIV * 2, 2);
    tag = "R8 toggle";
    for (int k = 0; k < 20; k++) begin
      disp_on = k[0];
      pattern = PW'(k * 37 + 11);
      run(2, 1);
    end
    disp_on = 1;
    tag = "R1 mid-frame reset";
    run(7, 1);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check_now();
    rst = 0;
    tag = "R1 R6 after reset";
    run(4 * DIV * 3, 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule